// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital controller of a dual-slope analog-to-digital converter. It walks each measurement through four phases in a fixed order: auto-zero, signal integrate, reference de-integrate and integrator zeroing. For each phase it drives one bit of a one-hot switch-control word toward the analog front end. It times the integrate phase, then counts de-integrate clocks until a zero-crossing comparator reports that the integrator has returned to its starting level. The count is proportional to the input-to-reference ratio.

The comparator is seen only as a one-bit digital input. Its level at the last integrate clock is kept as the polarity of the reading. Any later change of the comparator away from that level ends de-integrate. The result is a magnitude with a polarity bit and two range flags. A busy output marks the two integrating phases. The converter either runs freely, with a new integrate phase starting at a fixed period, or parks in auto-zero under a run/hold level and restarts on a rising edge.

Top module: `dsc_sequencer`

## Requirements
- R1: The switch word `sw_o` is one-hot, with bit 0 for auto-zero, bit 1 for integrate, bit 2 for de-integrate and bit 3 for zeroing. The phases follow one another as auto-zero, integrate, de-integrate, zeroing, auto-zero. The auto-zero bit is also the only bit set out of reset and while holding.
- R2: In free-run, consecutive integrate phases begin exactly `CYC_CLKS` clocks apart. The auto-zero phase absorbs whatever time the other phases leave over.
- R3: Integrate lasts exactly `INT_CLKS` clocks. `pol_o` takes the comparator level sampled on the last integrate clock and keeps it until the next integrate phase ends.
- R4: De-integrate ends on the first clock on which the comparator differs from the latched polarity. `count_o` then equals the number of de-integrate clocks that came before that clock (0 when the crossing arrives on the first clock).
- R5: If no crossing arrives within `DE_MAX` de-integrate clocks, the phase ends anyway. In that case `over_o` is set and `count_o` equals `DE_MAX-1`. A conversion that does cross clears `over_o`.
- R6: `under_o` is set when a completed conversion has no overrange and a count below `UNDER_LIM`. It is clear when the count equals `UNDER_LIM` or more.
- R7: The zeroing phase lasts `ZI_NORM` clocks. After an overrange it lasts `ZI_OVER` clocks instead.
- R8: `busy_o` is high from the first integrate clock through the last de-integrate clock, and low at every other time.
- R9: If the synchronized run level is low when a cycle completes, the block holds. In hold it keeps auto-zero asserted, raises no busy, and leaves `count_o`, `pol_o` and the flags unchanged.
- R10: While holding, a rising edge on `run_i` starts a new cycle. The block spends `AZ_START` clocks in auto-zero, and integrate begins `3+AZ_START` clocks after the edge is applied (two synchronizer stages plus one edge stage).
- R11: A high pulse on `run_i` that starts and ends inside a running cycle has no effect. The cycle still ends in hold.
- R12: Out of reset the block is in auto-zero with busy low, count zero and both flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Run (high) / hold (low) level, asynchronous |
| cmp_i | input | 1 | Zero-crossing comparator level |
| sw_o | output | 4 | One-hot phase switch controls {zero, de-int, int, auto-zero} |
| busy_o | output | 1 | High during integrate and de-integrate |
| pol_o | output | 1 | Latched polarity of the last reading |
| count_o | output | $clog2(DE_MAX) | Magnitude of the last reading |
| over_o | output | 1 | Last reading hit the de-integrate limit |
| under_o | output | 1 | Last reading below the underrange threshold |

## Verification
The assertions assume that the comparator only changes meaning at phase boundaries. They also assume that the run/hold input, once synchronized, is read only at cycle ends and in hold. The parameters must satisfy `INT_CLKS + DE_MAX + ZI_OVER < CYC_CLKS`, so that auto-zero never has a negative length. The stimulus keeps within these limits. The bench sets the comparator to the wanted polarity as soon as integrate is seen. It flips the comparator once, at a chosen de-integrate clock, or never, for overrange. It changes run/hold only on falling clock edges, with pulses at least three clocks wide, so that the synchronizer always catches them. The bench uses small parameter values so that whole cycles, including the overrange case, fit in a short run.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [2:0] {
        ST_AZ_START = 3'd0,
        ST_INTEG    = 3'd1,
        ST_DEINT    = 3'd2,
        ST_ZERO     = 3'd3,
        ST_AZ_FILL  = 3'd4,
        ST_HOLD     = 3'd5
    } dsc_state_e;

    localparam logic [3:0] SW_AZ   = 4'b0001;
    localparam logic [3:0] SW_INT  = 4'b0010;
    localparam logic [3:0] SW_DE   = 4'b0100;
    localparam logic [3:0] SW_ZERO = 4'b1000;

endpackage

// File: rtl/dsc_runsync.sv
module dsc_runsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);
    logic [STAGES-1:0] chain_d, chain_q;
    logic              prev_d, prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = async_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_comb prev_d = chain_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/dsc_result.sv
module dsc_result #(
    parameter int DE_MAX    = 20001,
    parameter int UNDER_LIM = 1000,
    localparam int CNTW     = $clog2(DE_MAX)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            over_i,
    input  logic [CNTW-1:0] cnt_i,
    output logic [CNTW-1:0] count_o,
    output logic            over_o,
    output logic            under_o
);
    localparam logic [CNTW-1:0] UNDER_V = CNTW'(UNDER_LIM);
    localparam logic [CNTW-1:0] CNT_TOP = CNTW'(DE_MAX - 1);

    logic [CNTW-1:0] count_d, count_q;
    logic            over_d, over_q, under_d, under_q;

    always_comb begin
        count_d = count_q;
        over_d  = over_q;
        under_d = under_q;
        if (load_i) begin
            count_d = cnt_i;
            over_d  = over_i;
            under_d = ~over_i & (cnt_i < UNDER_V);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            over_q  <= 1'b0;
            under_q <= 1'b0;
        end else begin
            count_q <= count_d;
            over_q  <= over_d;
            under_q <= under_d;
        end
    end

    assign count_o = count_q;
    assign over_o  = over_q;
    assign under_o = under_q;

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_TOP); // R5
    AST_HELD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(count_q) && $stable(over_q)); // R9
endmodule

// File: rtl/dsc_sequencer.sv
module dsc_sequencer
    import dsc_pkg::*;
#(
    parameter int CYC_CLKS  = 40002,
    parameter int INT_CLKS  = 10000,
    parameter int DE_MAX    = 20001,
    parameter int ZI_NORM   = 150,
    parameter int ZI_OVER   = 6200,
    parameter int AZ_START  = 1,
    parameter int UNDER_LIM = 1000,
    localparam int CNTW     = $clog2(DE_MAX)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic            cmp_i,
    output logic [3:0]      sw_o,
    output logic            busy_o,
    output logic            pol_o,
    output logic [CNTW-1:0] count_o,
    output logic            over_o,
    output logic            under_o
);
    localparam int CYCW = $clog2(CYC_CLKS);
    localparam logic [CYCW-1:0] INT_LAST = CYCW'(INT_CLKS - 1);
    localparam logic [CYCW-1:0] DE_LAST  = CYCW'(DE_MAX - 1);
    localparam logic [CYCW-1:0] ZN_LAST  = CYCW'(ZI_NORM - 1);
    localparam logic [CYCW-1:0] ZO_LAST  = CYCW'(ZI_OVER - 1);
    localparam logic [CYCW-1:0] AZ_LAST  = CYCW'(AZ_START - 1);
    localparam logic [CYCW-1:0] CYC_LAST = CYCW'(CYC_CLKS - 1);
    localparam logic [CYCW-1:0] ZN_LEN   = CYCW'(ZI_NORM);

    typedef struct packed {
        dsc_state_e      st;
        logic [CYCW-1:0] ph;
        logic [CYCW-1:0] cyc;
        logic            pol;
    } seq_t;

    seq_t r_d, r_q;
    logic run_lvl, run_rise;
    logic load, load_over;
    logic res_over;
    logic [CYCW-1:0] zero_last;

    dsc_runsync #(.STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (run_i),
        .level_o (run_lvl),
        .rise_o  (run_rise)
    );

    dsc_result #(.DE_MAX(DE_MAX), .UNDER_LIM(UNDER_LIM)) u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .over_i  (load_over),
        .cnt_i   (r_q.ph[CNTW-1:0]),
        .count_o (count_o),
        .over_o  (res_over),
        .under_o (under_o)
    );

    always_comb zero_last = res_over ? ZO_LAST : ZN_LAST;

    always_comb begin
        r_d       = r_q;
        load      = 1'b0;
        load_over = 1'b0;
        unique case (r_q.st)
            ST_AZ_START: begin
                r_d.ph = r_q.ph + 1'b1;
                if (r_q.ph == AZ_LAST) begin
                    r_d.st  = ST_INTEG;
                    r_d.ph  = '0;
                    r_d.cyc = '0;
                end
            end
            ST_INTEG: begin
                r_d.ph  = r_q.ph + 1'b1;
                r_d.cyc = r_q.cyc + 1'b1;
                if (r_q.ph == INT_LAST) begin
                    r_d.pol = cmp_i;
                    r_d.st  = ST_DEINT;
                    r_d.ph  = '0;
                end
            end
            ST_DEINT: begin
                r_d.cyc = r_q.cyc + 1'b1;
                r_d.ph  = r_q.ph + 1'b1;
                if (cmp_i != r_q.pol) begin
                    load   = 1'b1;
                    r_d.st = ST_ZERO;
                    r_d.ph = '0;
                end else if (r_q.ph == DE_LAST) begin
                    load      = 1'b1;
                    load_over = 1'b1;
                    r_d.st    = ST_ZERO;
                    r_d.ph    = '0;
                end
            end
            ST_ZERO: begin
                r_d.cyc = r_q.cyc + 1'b1;
                r_d.ph  = r_q.ph + 1'b1;
                if (r_q.ph == zero_last) begin
                    r_d.st = ST_AZ_FILL;
                    r_d.ph = '0;
                end
            end
            ST_AZ_FILL: begin
                r_d.cyc = r_q.cyc + 1'b1;
                if (r_q.cyc == CYC_LAST) begin
                    r_d.cyc = '0;
                    r_d.ph  = '0;
                    r_d.st  = run_lvl ? ST_INTEG : ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (run_rise) begin
                    r_d.st = ST_AZ_START;
                    r_d.ph = '0;
                end
            end
            default: r_d.st = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_AZ_START;
            r_q.ph  <= '0;
            r_q.cyc <= '0;
            r_q.pol <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (r_q.st)
            ST_INTEG: sw_o = SW_INT;
            ST_DEINT: sw_o = SW_DE;
            ST_ZERO:  sw_o = SW_ZERO;
            default:  sw_o = SW_AZ;
        endcase
    end

    assign busy_o = (r_q.st == ST_INTEG) || (r_q.st == ST_DEINT);
    assign pol_o  = r_q.pol;
    assign over_o = res_over;

    AST_INT_TO_DE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_INTEG) |=> (r_q.st == ST_INTEG) || (r_q.st == ST_DEINT)); // R1
    AST_DE_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DEINT) |=> (r_q.st == ST_DEINT) || (r_q.st == ST_ZERO)); // R1
    AST_CYC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cyc <= CYC_LAST); // R2
    AST_POL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DEINT) |=> $stable(r_q.pol)); // R3
    AST_LONG_ZERO_OVER: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_ZERO) && (r_q.ph >= ZN_LEN)) |-> res_over); // R7
    AST_HOLD_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_HOLD) && !run_rise) |=> (r_q.st == ST_HOLD)); // R10
endmodule

// File: tb/dsc_sequencer_test.sv
module dsc_sequencer_test;
    localparam int CYC   = 100;
    localparam int INTC  = 20;
    localparam int DEMX  = 41;
    localparam int ZN    = 5;
    localparam int ZO    = 30;
    localparam int AZS   = 3;
    localparam int ULIM  = 4;
    localparam int CNTW  = $clog2(DEMX);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_i = 1'b1;
    logic cmp_i = 1'b0;
    logic [3:0] sw_o;
    logic busy_o, pol_o, over_o, under_o;
    logic [CNTW-1:0] count_o;

    int checks = 0;
    int fails = 0;
    int tick = 0;
    int last_int = -1;
    bit done = 0;

    always #2 clk = ~clk;
    always @(posedge clk) tick <= tick + 1;

    dsc_sequencer #(
        .CYC_CLKS(CYC), .INT_CLKS(INTC), .DE_MAX(DEMX), .ZI_NORM(ZN),
        .ZI_OVER(ZO), .AZ_START(AZS), .UNDER_LIM(ULIM)
    ) uut (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .cmp_i(cmp_i),
        .sw_o(sw_o), .busy_o(busy_o), .pol_o(pol_o), .count_o(count_o),
        .over_o(over_o), .under_o(under_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One conversion. k < 0 means never cross (overrange).
    // hold_mode drops run during integrate with a short high pulse inside it.
    task automatic convert(input bit pol, input int k, input bit hold_mode,
                           input int exp_period);
        int n;
        int zl;
        int ek;
        while (sw_o != 4'b0010) @(negedge clk);
        if (exp_period > 0 && last_int >= 0)
            check("R2 cycle period", tick - last_int, exp_period);
        last_int = tick;
        cmp_i = pol;
        n = 0;
        while (sw_o == 4'b0010) begin
            check("R8 busy in integrate", busy_o, 1);
            if (hold_mode) begin
                if (n == 0) run_i = 1'b0;
                if (n == 3) run_i = 1'b1;   // R11 pulse inside the cycle
                if (n == 6) run_i = 1'b0;
            end
            n++;
            @(negedge clk);
        end
        check("R3 integrate length", n, INTC);
        check("R1 integrate then de-integrate", sw_o, 4'b0100);
        if (k >= 0) begin
            repeat (k) @(negedge clk);
            cmp_i = ~pol;
            @(negedge clk);
            ek = k;
        end else begin
            n = 0;
            while (sw_o == 4'b0100) begin n++; @(negedge clk); end
            check("R5 de-integrate limit", n, DEMX);
            ek = DEMX - 1;
        end
        check("R1 de-integrate then zero", sw_o, 4'b1000);
        check("R8 busy low after de-integrate", busy_o, 0);
        check("R4 count", count_o, ek);
        check("R3 polarity", pol_o, pol);
        check("R5 overrange flag", over_o, (k < 0) ? 1 : 0);
        check("R6 underrange flag", under_o, (k >= 0 && k < ULIM) ? 1 : 0);
        zl = 0;
        while (sw_o == 4'b1000) begin zl++; @(negedge clk); end
        check("R7 zeroing length", zl, (k < 0) ? ZO : ZN);
        check("R1 zero then auto-zero", sw_o, 4'b0001);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check("R12 reset switch word", sw_o, 4'b0001);
        check("R12 reset busy", busy_o, 0);
        check("R12 reset count", count_o, 0);
        check("R12 reset flags", {over_o, under_o}, 0);
        rst_n = 1'b1;
    endtask

    task automatic test_free_run();
        convert(1'b0, 10, 1'b0, 0);
        convert(1'b1, 0, 1'b0, CYC);
        convert(1'b0, ULIM, 1'b0, CYC);
        convert(1'b1, ULIM - 1, 1'b0, CYC);
    endtask

    task automatic test_overrange();
        convert(1'b0, -1, 1'b0, CYC);
        convert(1'b1, 7, 1'b0, CYC);
    endtask

    task automatic test_hold();
        int bad;
        int n;
        convert(1'b0, 9, 1'b1, CYC);
        bad = 0;
        repeat (2 * CYC) begin
            @(negedge clk);
            if (sw_o != 4'b0001 || busy_o) bad++;
        end
        check("R9 hold keeps auto-zero, no busy", bad, 0);
        check("R11 pulse ignored, reading held", count_o, 9);
        check("R9 polarity held", pol_o, 0);
        run_i = 1'b1;
        n = 0;
        bad = 0;
        while (!busy_o) begin
            @(negedge clk);
            n++;
            if (n == 3) run_i = 1'b0;
            if (!busy_o && sw_o != 4'b0001) bad++;
        end
        check("R10 restart delay", n, 3 + AZS);
        check("R10 auto-zero before integrate", bad, 0);
        last_int = -1;
        convert(1'b1, 12, 1'b0, 0);
        bad = 0;
        repeat (2 * CYC) begin
            @(negedge clk);
            if (busy_o) bad++;
        end
        check("R10 single pulse gives single cycle", bad, 0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_free_run();
        test_overrange();
        test_hold();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule